// File: doc/BRIEF.md
# One-time programmable fuse memory

This block models a small one-time programmable memory built from fusible cells. Every cell starts intact and reads 1. Programming a word can only blow cells, which turns them to 0, and a blown cell cannot be restored. The array has `2**ADDR_W` words of `DATA_W` bits. Each word is read through a registered read port. A direct program port lets a controller apply one word at a time.

A built-in sequencer programs a whole image without help. After a start pulse it steps through every location in ascending order and presents the location on `img_addr`. The image source answers on `img_data` in the same cycle. The sequencer spends one cycle programming the location and one cycle verifying it. It raises a conflict flag when the image asks for a 1 where the cell has already been blown. It raises a mismatch flag when the read-back word differs from the target. In both cases it continues to the next location.

Top module: `otp_fuse_mem`

## Requirements
- R1: The read port returns the word at `rd_addr` one clock after the address is sampled, and each address selects its own word.
- R2: While `factory_clr` is high at a clock edge, every cell becomes 1. This path exists for simulation only.
- R3: A program operation stores old AND data. Programming 1010 into location 3 of an erased array clears bits 0 and 2 and leaves bits 1 and 3 at 1.
- R4: No operation other than `factory_clr` changes a cell from 0 to 1.
- R5: Asserting `rst_n` leaves the array contents unchanged.
- R6: A read and a program of the same address in the same cycle return the word as it was before that program.
- R7: A `seq_start` pulse while idle begins a run. For 2·DEPTH cycles `seq_busy` is high and `img_addr` holds location k for the k-th pair of cycles (program, then verify). After that, `seq_done` is high for exactly one cycle. Every location then holds old AND image.
- R8: `seq_conflict` is set during a run when any location has an image bit of 1 over a cell of 0. The run still programs every location. The flag stays set until the next accepted start clears it.
- R9: `seq_mismatch` is set when a location read back in its verify cycle differs from its image word. It follows the same clearing rule as R8.
- R10: While `seq_busy` is high, `pg_en` has no effect.
- R11: A `seq_start` pulse while a run is in progress is ignored and does not restart the walk.
- R12: After reset the sequencer is idle with `seq_busy`, `seq_done`, `seq_conflict` and `seq_mismatch` low, and `rd_data` reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for control state; array contents are kept |
| factory_clr | input | 1 | Simulation-only restore of every cell to 1 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| pg_en | input | 1 | Direct program strobe |
| pg_addr | input | ADDR_W | Direct program address |
| pg_data | input | DATA_W | Direct program word; each 0 bit blows the matching cell |
| seq_start | input | 1 | Start pulse for an image run |
| img_addr | output | ADDR_W | Location currently handled by the sequencer |
| img_data | input | DATA_W | Image word for `img_addr`, supplied in the same cycle |
| seq_busy | output | 1 | Run in progress |
| seq_done | output | 1 | One-cycle pulse at the end of a run |
| seq_conflict | output | 1 | Sticky: the image needed a blown cell back at 1 |
| seq_mismatch | output | 1 | Sticky: a verify read-back differed from the image |

## Verification
Two pairs of operations can meet in one clock. The first pair is a read and a direct program of the same word. The bench issues both in one cycle and expects the pre-program word, then reads again and expects the cleared word. The second pair is a direct program, or a second start pulse, arriving during a sequencer run. The bench pulses `pg_en` at an already-processed location and pulses `seq_start` mid-run. It then judges the final contents against old AND image, checks the `img_addr` walk cycle by cycle, and checks the done timing.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_PROG   = 2'd1,
      SQ_VERIFY = 2'd2,
      SQ_DONE   = 2'd3
   } seq_state_t;

   // Bits the target wants at 1 that are already blown
   function automatic logic any_unblowable(input logic [63:0] target, input logic [63:0] current);
      return |(target & ~current);
   endfunction

endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear_all,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_keep,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic [(DATA_W<<ADDR_W)-1:0]  cells_flat
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_view [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] q;
      // Contents have no reset: only clear_all restores ones
      always_ff @(posedge clk) begin
         if (clear_all)
            q <= '1;
         else if (wr_en && (wr_addr == ADDR_W'(i)))
            q <= q & wr_keep;
      end
      assign word_view[i] = q;
      assign cells_flat[i*DATA_W +: DATA_W] = q;
   end

   // Registered read: samples the word before this edge's update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '1;
      else
         rd_data <= word_view[rd_addr];
   end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
   import otp_fuse_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] target,
   input  logic [DATA_W-1:0] cur_word,
   output logic [ADDR_W-1:0] loc,
   output logic              wr_en,
   output logic              busy,
   output logic              done,
   output logic              conflict,
   output logic              mismatch
);
   seq_state_t        st;
   logic [ADDR_W-1:0] idx;
   logic              cant_set;

   assign cant_set = any_unblowable(64'(target), 64'(cur_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         idx      <= '0;
         conflict <= 1'b0;
         mismatch <= 1'b0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  st       <= SQ_PROG;
                  idx      <= '0;
                  conflict <= 1'b0;
                  mismatch <= 1'b0;
               end
            end
            SQ_PROG: begin
               if (cant_set) conflict <= 1'b1;
               st <= SQ_VERIFY;
            end
            SQ_VERIFY: begin
               if (cur_word != target) mismatch <= 1'b1;
               if (idx == '1) begin
                  st <= SQ_DONE;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= SQ_PROG;
               end
            end
            SQ_DONE: st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign loc   = idx;
   assign wr_en = (st == SQ_PROG);
   assign busy  = (st == SQ_PROG) || (st == SQ_VERIFY);
   assign done  = (st == SQ_DONE);

endmodule

// File: rtl/otp_fuse_mem.sv
module otp_fuse_mem #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              factory_clr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pg_en,
   input  logic [ADDR_W-1:0] pg_addr,
   input  logic [DATA_W-1:0] pg_data,
   input  logic              seq_start,
   output logic [ADDR_W-1:0] img_addr,
   input  logic [DATA_W-1:0] img_data,
   output logic              seq_busy,
   output logic              seq_done,
   output logic              seq_conflict,
   output logic              seq_mismatch
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int FLAT  = DEPTH * DATA_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("otp_fuse_mem: ADDR_W must lie in 1..10");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
      $error("otp_fuse_mem: DATA_W must lie in 1..64");
   end

   logic [FLAT-1:0]   cells_flat;
   logic [DATA_W-1:0] seq_word;
   logic              seq_wr;
   logic              arr_wr;
   logic [ADDR_W-1:0] arr_addr;
   logic [DATA_W-1:0] arr_keep;

   assign seq_word = cells_flat[img_addr*DATA_W +: DATA_W];

   // Sequencer owns the write path for the whole run
   always_comb begin
      if (seq_busy) begin
         arr_wr   = seq_wr;
         arr_addr = img_addr;
         arr_keep = img_data;
      end else begin
         arr_wr   = pg_en;
         arr_addr = pg_addr;
         arr_keep = pg_data;
      end
   end

   otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_all  (factory_clr),
      .wr_en      (arr_wr),
      .wr_addr    (arr_addr),
      .wr_keep    (arr_keep),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .cells_flat (cells_flat)
   );

   otp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (seq_start),
      .target   (img_data),
      .cur_word (seq_word),
      .loc      (img_addr),
      .wr_en    (seq_wr),
      .busy     (seq_busy),
      .done     (seq_done),
      .conflict (seq_conflict),
      .mismatch (seq_mismatch)
   );

endmodule

// File: rtl/otp_fuse_mem_chk.sv
module otp_fuse_mem_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        factory_clr,
   input logic                        seq_start,
   input logic [ADDR_W-1:0]           img_addr,
   input logic                        seq_busy,
   input logic                        seq_done,
   input logic                        seq_conflict,
   input logic [(DATA_W<<ADDR_W)-1:0] cells
);
   // R2: a factory clear leaves every cell intact
   p_clear_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      factory_clr |=> (&cells));

   // R4: without a factory clear no cell goes from 0 to 1
   p_no_unblow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !factory_clr |=> ((cells & ~$past(cells)) == '0));

   // R7: the done pulse follows a busy cycle and lasts one cycle
   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_done) |-> (!seq_busy && $past(seq_busy)));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R7: the walk only moves up by one location
   p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && $past(seq_busy) && (img_addr != $past(img_addr)))
         |-> (img_addr == $past(img_addr) + 1'b1));

   // R8: the conflict flag holds until an accepted start
   p_conflict_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_conflict && !(seq_start && !seq_busy && !seq_done)) |=> seq_conflict);

   // R11: a mid-run start does not send the walk back to location 0
   p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && (img_addr != '0)) |=> (!seq_busy || (img_addr != '0)));

endmodule

bind otp_fuse_mem otp_fuse_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .factory_clr  (factory_clr),
   .seq_start    (seq_start),
   .img_addr     (img_addr),
   .seq_busy     (seq_busy),
   .seq_done     (seq_done),
   .seq_conflict (seq_conflict),
   .cells        (cells_flat)
);

// File: tb/otp_fuse_mem_bench.sv
module otp_fuse_mem_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = 3;
   localparam int DW = 4;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n, factory_clr, pg_en, seq_start;
   logic [AW-1:0] rd_addr, pg_addr, img_addr;
   logic [DW-1:0] rd_data, pg_data, img_data;
   logic          seq_busy, seq_done, seq_conflict, seq_mismatch;

   logic [DW-1:0] model [N];
   logic [DW-1:0] img   [N];

   int errs   = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   assign img_data = img[img_addr];

   otp_fuse_mem #(.ADDR_W(AW), .DATA_W(DW)) u_otp_fuse_mem (
      .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
      .seq_start(seq_start), .img_addr(img_addr), .img_data(img_data),
      .seq_busy(seq_busy), .seq_done(seq_done),
      .seq_conflict(seq_conflict), .seq_mismatch(seq_mismatch)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk) rd_addr = a;
      @(negedge clk) v = rd_data;
   endtask

   task automatic pgm(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      pg_en = 1'b1; pg_addr = a; pg_data = d;
      @(negedge clk) pg_en = 1'b0;
      model[a] = model[a] & d;
   endtask

   task automatic sweep(input string req);
      logic [DW-1:0] v;
      for (int a = 0; a < N; a++) begin
         rd(AW'(a), v);
         chk(req, 32'(v), 32'(model[a]));
      end
   endtask

   task automatic run_seq(input bit poke);
      logic exp_flag;
      exp_flag = 1'b0;
      for (int a = 0; a < N; a++)
         if ((img[a] & ~model[a]) != '0) exp_flag = 1'b1;
      @(negedge clk) seq_start = 1'b1;
      @(negedge clk) seq_start = 1'b0;
      chk("R8 flag cleared by start", 32'(seq_conflict), 32'(0));
      chk("R9 flag cleared by start", 32'(seq_mismatch), 32'(0));
      for (int k = 0; k < 2 * N; k++) begin
         chk("R7 busy during walk", 32'(seq_busy), 32'(1));
         chk("R7 walk address", 32'(img_addr), 32'(k / 2));
         if (poke && k == 3) begin
            pg_en = 1'b1; pg_addr = '0; pg_data = '0;   // R10 stimulus
         end
         if (poke && k == 4) pg_en = 1'b0;
         if (poke && k == 5) seq_start = 1'b1;           // R11 stimulus
         if (poke && k == 6) seq_start = 1'b0;
         @(negedge clk);
      end
      chk("R7 done pulse", 32'(seq_done), 32'(1));
      chk("R7 busy low at done", 32'(seq_busy), 32'(0));
      chk("R8 conflict flag", 32'(seq_conflict), 32'(exp_flag));
      chk("R9 mismatch flag", 32'(seq_mismatch), 32'(exp_flag));
      @(negedge clk);
      chk("R7 done one cycle", 32'(seq_done), 32'(0));
      for (int a = 0; a < N; a++) model[a] = model[a] & img[a];
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      rst_n = 1'b0; factory_clr = 1'b1; pg_en = 1'b0; seq_start = 1'b0;
      rd_addr = '0; pg_addr = '0; pg_data = '0;
      for (int a = 0; a < N; a++) begin model[a] = '1; img[a] = '1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk) factory_clr = 1'b0;

      // R12 reset state
      chk("R12 busy", 32'(seq_busy), 32'(0));
      chk("R12 done", 32'(seq_done), 32'(0));
      chk("R12 conflict", 32'(seq_conflict), 32'(0));
      chk("R12 mismatch", 32'(seq_mismatch), 32'(0));
      chk("R12 rd_data", 32'(rd_data), 32'hF);

      sweep("R2 erased reads ones");

      // R3: 1010 into location 3
      pgm(3'd3, 4'b1010);
      rd(3'd3, v);
      chk("R3 location 3 holds 1010", 32'(v), 32'hA);

      // R1/R3: distinct words at each address
      for (int a = 0; a < N; a++) pgm(AW'(a), DW'(a * 7 + 9));
      sweep("R1 R3 per-address AND");

      // R4: ones cannot return
      pgm(3'd3, 4'hF);
      pgm(3'd1, 4'hF);
      rd(3'd3, v);
      chk("R4 no unblow loc3", 32'(v), 32'(model[3]));
      rd(3'd1, v);
      chk("R4 no unblow loc1", 32'(v), 32'(model[1]));

      // R6: same-cycle read and program
      @(negedge clk);
      pg_en = 1'b1; pg_addr = 3'd6; pg_data = 4'h0; rd_addr = 3'd6;
      @(negedge clk) pg_en = 1'b0;
      chk("R6 read sees old word", 32'(rd_data), 32'(model[6]));
      model[6] = '0;
      rd(3'd6, v);
      chk("R6 later read sees new word", 32'(v), 32'(0));

      // R5: reset keeps contents
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      sweep("R5 contents survive reset");

      // R2: factory clear
      @(negedge clk) factory_clr = 1'b1;
      @(negedge clk) factory_clr = 1'b0;
      for (int a = 0; a < N; a++) model[a] = '1;
      sweep("R2 factory clear");

      // Run A: compatible image, with mid-run program and start pulses
      for (int a = 0; a < N; a++) img[a] = DW'(a) ^ 4'h5;
      run_seq(1'b1);
      sweep("R7 R10 R11 contents after run");

      // Run B: location 5 asks for ones over blown cells
      for (int a = 0; a < N; a++) img[a] = (a % 2 == 0) ? model[a] : (model[a] & 4'h9);
      img[5] = 4'hF;
      run_seq(1'b0);
      sweep("R8 R9 run continues past conflict");

      // Run C: image equals contents, flags stay clear
      for (int a = 0; a < N; a++) img[a] = model[a];
      run_seq(1'b0);
      sweep("R8 clean run contents");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule